// File: doc/BRIEF.md
# SP Output Block Packer with Latched Sync Errors

For one bunch crossing, this block assembles the track-finder's output block and sends it out as a stream of 16-bit words, one word per clock. A flag marks the final word. A start pulse captures a snapshot of the inputs: the readout configuration, the barrel-muon frames with their qualities, the three output tracks with their modes, and one PT-LUT frame. The block then walks a small state machine through the snapshot. Entries that the configuration drops take no cycles.

The first word of every block is a 15-bit sync-error vector, one bit per endcap muon. Each bit combines three sources:
- a link error seen in this crossing only;
- a front-side loss of sync on the link, which stays latched;
- a loss of sync toward a front FPGA, seen on the SP side, which stays latched and covers all three muons of that FPGA.

Latched bits hold until the L1 Reset input. The second word carries the track modes and the nonzero-quality marks of the two barrel muons. The data words follow in a fixed order.

The state machine has six states. IDLE waits for an accepted start. SYNC emits the error vector. MODE emits the mode word. MBF emits barrel frames. TRKF emits track frames. PTLF emits the single PT-LUT frame. The transitions are:
- IDLE to SYNC on an accepted start.
- SYNC to MODE always.
- MODE to MBF, TRKF or IDLE, depending on which entries remain.
- MBF stays in MBF for the next frame or the next barrel muon, then moves to TRKF or IDLE.
- TRKF moves to PTLF when the finished track is the one the PT-LUT select names. Otherwise it stays in TRKF for the next track or returns to IDLE.
- PTLF moves to TRKF or IDLE.

Top module: `sp_data_packer`

## Requirements
- R1: A start is accepted only in IDLE with a crossing count greater than 0. The first word then appears in the cycle after the start. A start with a count of 0, or a start while a block is streaming, emits nothing and leaves the current block unchanged.
- R2: Word 0 is {0, err[14:0]}. Muon m sits at bit m, and front FPGA f serves bits 3f to 3f+2. A link error sets its bit only in the block of the crossing where it was applied.
- R3: A front-side sync loss on muon m sets bit m in the current block and in every later block until L1 Reset.
- R4: An SP-side sync loss on FPGA f sets bits 3f to 3f+2 in the current block and in every later block until L1 Reset.
- R5: L1 Reset clears every latched bit. In the cycle it is high, only that cycle's sources appear in a word 0 started then, and nothing from that cycle is latched.
- R6: Word 1 carries three track modes and two barrel marks:
  - bits [3:0] hold the mode of track 1, [7:4] track 2 and [11:8] track 3;
  - bit 12 is 1 when the MB1A quality is nonzero, and bit 13 is 1 when the MB1D quality is nonzero;
  - bits 15:14 are 0.
- R7: Barrel muons appear only when MB-active is set. Without zero suppression both appear; with it, only those with nonzero quality appear. Each barrel muon gives frame 1 then frame 2, and MB1A comes before MB1D.
- R8: Tracks follow the barrel muons in the order 1, 2, 3, three frames each. Without zero suppression all three appear; with it, only tracks with a nonzero mode appear.
- R9: A PT-LUT select of k (1 to 3) inserts the PT-LUT frame once, right after the third frame of track k, and only if track k is included. A select of 0 inserts no PT-LUT frame.
- R10: Words of a block come in consecutive cycles. Bit 15 is 0 in every word. The last flag is high on the final word only. A block holds 2 to 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l1_reset_i | input | 1 | Clears the latched sync-error bits |
| start_i | input | 1 | Request one block for the current crossing |
| num_bx_i | input | 3 | Crossing count; 0 disables the block |
| zero_sup_i | input | 1 | Zero suppression enable |
| mb_active_i | input | 1 | Include barrel muon data |
| ptlut_sel_i | input | 2 | PT-LUT frame select (0 = none, k = after track k) |
| link_err_i | input | 15 | Per-muon single-crossing link errors |
| front_loss_i | input | 15 | Per-muon front-side sync loss (latched) |
| sp_loss_i | input | 5 | Per-FPGA SP-side sync loss (latched, 3 muons each) |
| mb_qual_i | input | 6 | Barrel qualities, MB1A at [2:0], MB1D at [5:3] |
| mb_frames_i | input | 60 | Barrel frames, 15 bits each, muon i frame f at slot 2i+f |
| trk_mode_i | input | 12 | Track modes, track k+1 at [4k+3:4k] |
| trk_frames_i | input | 135 | Track frames, 15 bits each, track k frame f at slot 3k+f |
| ptlut_frame_i | input | 15 | PT-LUT frame |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 16 | Output word |
| out_last_o | output | 1 | Final word of the block |

## Verification
The inputs are driven, and the outputs sampled, on the falling clock edge.
- Word 0 of an accepted start is sampled at the falling edge right after the rising edge that accepts it. Each later word is sampled one falling edge later. At the falling edge after the last word, the bench expects the valid output low.
- A latched error takes effect at the rising edge after it is driven. The bench model updates its latched vector in that same step, so the next block's word 0 is predicted without any lag.
- A rejected start, whether it has a count of 0 or arrives while busy, is checked by watching the valid output for the next two falling edges, or by comparing the ongoing stream word by word.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_MODE,
        ST_MBF,
        ST_TRKF,
        ST_PTLF
    } pack_state_t;

endpackage

// File: rtl/sp_sync_err_tracker.sv
module sp_sync_err_tracker #(
    parameter int unsigned N_FPGA      = 5,
    parameter int unsigned MU_PER_FPGA = 3,
    localparam int unsigned N_MU       = N_FPGA * MU_PER_FPGA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_reset_i,
    input  logic [N_MU-1:0]   link_err_i,
    input  logic [N_MU-1:0]   front_loss_i,
    input  logic [N_FPGA-1:0] sp_loss_i,
    output logic [N_MU-1:0]   err_vec_o,
    output logic [N_MU-1:0]   sticky_o
);

    logic [N_MU-1:0] sp_spread;
    logic [N_MU-1:0] latch_src;
    logic [N_MU-1:0] sticky_q;

    for (genvar f = 0; f < N_FPGA; f++) begin : g_spread
        assign sp_spread[f*MU_PER_FPGA +: MU_PER_FPGA] = {MU_PER_FPGA{sp_loss_i[f]}};
    end

    assign latch_src = front_loss_i | sp_spread;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else if (l1_reset_i) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= sticky_q | latch_src;
        end
    end

    assign err_vec_o = link_err_i | latch_src | (l1_reset_i ? '0 : sticky_q);
    assign sticky_o  = sticky_q;

endmodule

// File: rtl/sp_pack_select.sv
module sp_pack_select #(
    parameter int unsigned N_MB       = 2,
    parameter int unsigned N_TRK      = 3,
    parameter int unsigned MB_FRAMES  = 2,
    parameter int unsigned TRK_FRAMES = 3,
    parameter int unsigned MODE_W     = 4,
    parameter int unsigned MBQ_W      = 3,
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned LEN_W      = 5
) (
    input  logic                    zero_sup_i,
    input  logic                    mb_active_i,
    input  logic [SEL_W-1:0]        ptlut_sel_i,
    input  logic [N_MB*MBQ_W-1:0]   mb_qual_i,
    input  logic [N_TRK*MODE_W-1:0] trk_mode_i,
    output logic [N_MB-1:0]         mb_nz_o,
    output logic [N_MB-1:0]         mb_inc_o,
    output logic [N_TRK-1:0]        trk_inc_o,
    output logic [N_TRK-1:0]        pt_inc_o,
    output logic [LEN_W-1:0]        blk_len_o
);

    for (genvar i = 0; i < N_MB; i++) begin : g_mb
        assign mb_nz_o[i]  = |mb_qual_i[i*MBQ_W +: MBQ_W];
        assign mb_inc_o[i] = mb_active_i && (!zero_sup_i || mb_nz_o[i]);
    end

    for (genvar k = 0; k < N_TRK; k++) begin : g_trk
        assign trk_inc_o[k] = !zero_sup_i || (|trk_mode_i[k*MODE_W +: MODE_W]);
        assign pt_inc_o[k]  = trk_inc_o[k] && (ptlut_sel_i == SEL_W'(k + 1));
    end

    always_comb begin
        blk_len_o = LEN_W'(2);
        for (int i = 0; i < N_MB; i++) begin
            if (mb_inc_o[i]) blk_len_o = blk_len_o + LEN_W'(MB_FRAMES);
        end
        for (int k = 0; k < N_TRK; k++) begin
            if (trk_inc_o[k]) blk_len_o = blk_len_o + LEN_W'(TRK_FRAMES);
        end
        if (|pt_inc_o) blk_len_o = blk_len_o + LEN_W'(1);
    end

endmodule

// File: rtl/sp_data_packer.sv
module sp_data_packer
    import sp_pack_pkg::*;
#(
    parameter int unsigned N_FPGA      = 5,
    parameter int unsigned MU_PER_FPGA = 3,
    parameter int unsigned N_MB        = 2,
    parameter int unsigned MB_FRAMES   = 2,
    parameter int unsigned N_TRK       = 3,
    parameter int unsigned TRK_FRAMES  = 3,
    parameter int unsigned MODE_W      = 4,
    parameter int unsigned MBQ_W       = 3,
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned BX_W        = 3,
    parameter int unsigned WORD_W      = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               l1_reset_i,
    input  logic                               start_i,
    input  logic [BX_W-1:0]                    num_bx_i,
    input  logic                               zero_sup_i,
    input  logic                               mb_active_i,
    input  logic [SEL_W-1:0]                   ptlut_sel_i,
    input  logic [N_FPGA*MU_PER_FPGA-1:0]      link_err_i,
    input  logic [N_FPGA*MU_PER_FPGA-1:0]      front_loss_i,
    input  logic [N_FPGA-1:0]                  sp_loss_i,
    input  logic [N_MB*MBQ_W-1:0]              mb_qual_i,
    input  logic [N_MB*MB_FRAMES*(WORD_W-1)-1:0] mb_frames_i,
    input  logic [N_TRK*MODE_W-1:0]            trk_mode_i,
    input  logic [N_TRK*TRK_FRAMES*(WORD_W-1)-1:0] trk_frames_i,
    input  logic [WORD_W-2:0]                  ptlut_frame_i,
    output logic                               out_valid_o,
    output logic [WORD_W-1:0]                  out_data_o,
    output logic                               out_last_o
);

    localparam int unsigned N_MU    = N_FPGA * MU_PER_FPGA;
    localparam int unsigned DW      = WORD_W - 1;
    localparam int unsigned MAX_LEN = 2 + N_MB*MB_FRAMES + N_TRK*TRK_FRAMES + 1;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);
    localparam int unsigned MAXF    = (MB_FRAMES > TRK_FRAMES) ? MB_FRAMES : TRK_FRAMES;
    localparam int unsigned FRC_W   = (MAXF > 1) ? $clog2(MAXF) : 1;
    localparam int unsigned MBI_W   = (N_MB > 1) ? $clog2(N_MB) : 1;
    localparam int unsigned TRI_W   = (N_TRK > 1) ? $clog2(N_TRK) : 1;

    // ---------------- error tracking and selection ----------------
    logic [N_MU-1:0] err_vec;
    logic [N_MU-1:0] sticky_w;

    sp_sync_err_tracker #(
        .N_FPGA      (N_FPGA),
        .MU_PER_FPGA (MU_PER_FPGA)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .l1_reset_i   (l1_reset_i),
        .link_err_i   (link_err_i),
        .front_loss_i (front_loss_i),
        .sp_loss_i    (sp_loss_i),
        .err_vec_o    (err_vec),
        .sticky_o     (sticky_w)
    );

    logic [N_MB-1:0]  mb_nz, mb_inc;
    logic [N_TRK-1:0] trk_inc, pt_inc;
    logic [LEN_W-1:0] blk_len;

    sp_pack_select #(
        .N_MB       (N_MB),
        .N_TRK      (N_TRK),
        .MB_FRAMES  (MB_FRAMES),
        .TRK_FRAMES (TRK_FRAMES),
        .MODE_W     (MODE_W),
        .MBQ_W      (MBQ_W),
        .SEL_W      (SEL_W),
        .LEN_W      (LEN_W)
    ) u_sel (
        .zero_sup_i  (zero_sup_i),
        .mb_active_i (mb_active_i),
        .ptlut_sel_i (ptlut_sel_i),
        .mb_qual_i   (mb_qual_i),
        .trk_mode_i  (trk_mode_i),
        .mb_nz_o     (mb_nz),
        .mb_inc_o    (mb_inc),
        .trk_inc_o   (trk_inc),
        .pt_inc_o    (pt_inc),
        .blk_len_o   (blk_len)
    );

    // ---------------- state and snapshot registers ----------------
    pack_state_t      state_q, state_d;
    logic [FRC_W-1:0] fr_q, fr_d;
    logic [N_MB-1:0]  mb_pend_q, mb_pend_d;
    logic [N_TRK-1:0] trk_pend_q, trk_pend_d;
    logic [N_TRK-1:0] pt_pend_q, pt_pend_d;
    logic [LEN_W-1:0] rem_q, rem_d;

    logic [N_MU-1:0]                     sync_q;
    logic [DW-1:0]                       modew_q;
    logic [N_MB*MB_FRAMES*DW-1:0]        mb_frames_q;
    logic [N_TRK*TRK_FRAMES*DW-1:0]      trk_frames_q;
    logic [DW-1:0]                       pt_frame_q;

    logic accept;
    assign accept = start_i && (state_q == ST_IDLE) && (num_bx_i != '0);

    // current entry: lowest pending index
    logic [MBI_W-1:0] mb_cur;
    logic [N_MB-1:0]  mb_cur_oh;
    logic [TRI_W-1:0] trk_cur;
    logic [N_TRK-1:0] trk_cur_oh;
    int unsigned      mb_pos, trk_pos;

    always_comb begin
        mb_cur    = '0;
        mb_cur_oh = '0;
        for (int i = N_MB - 1; i >= 0; i--) begin
            if (mb_pend_q[i]) mb_cur = MBI_W'(i);
        end
        mb_cur_oh[mb_cur] = 1'b1;
        trk_cur    = '0;
        trk_cur_oh = '0;
        for (int k = N_TRK - 1; k >= 0; k--) begin
            if (trk_pend_q[k]) trk_cur = TRI_W'(k);
        end
        trk_cur_oh[trk_cur] = 1'b1;
        mb_pos  = 32'(mb_cur) * MB_FRAMES + 32'(fr_q);
        trk_pos = 32'(trk_cur) * TRK_FRAMES + 32'(fr_q);
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        fr_d       = fr_q;
        mb_pend_d  = mb_pend_q;
        trk_pend_d = trk_pend_q;
        pt_pend_d  = pt_pend_q;
        rem_d      = rem_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d    = ST_SYNC;
                    fr_d       = '0;
                    mb_pend_d  = mb_inc;
                    trk_pend_d = trk_inc;
                    pt_pend_d  = pt_inc;
                    rem_d      = blk_len;
                end
            end
            ST_SYNC: begin
                rem_d   = rem_q - LEN_W'(1);
                state_d = ST_MODE;
            end
            ST_MODE: begin
                rem_d = rem_q - LEN_W'(1);
                fr_d  = '0;
                if (|mb_pend_q)       state_d = ST_MBF;
                else if (|trk_pend_q) state_d = ST_TRKF;
                else                  state_d = ST_IDLE;
            end
            ST_MBF: begin
                rem_d = rem_q - LEN_W'(1);
                if (fr_q == FRC_W'(MB_FRAMES - 1)) begin
                    fr_d      = '0;
                    mb_pend_d = mb_pend_q & ~mb_cur_oh;
                    if (|mb_pend_d)       state_d = ST_MBF;
                    else if (|trk_pend_q) state_d = ST_TRKF;
                    else                  state_d = ST_IDLE;
                end else begin
                    fr_d = fr_q + FRC_W'(1);
                end
            end
            ST_TRKF: begin
                rem_d = rem_q - LEN_W'(1);
                if (fr_q == FRC_W'(TRK_FRAMES - 1)) begin
                    fr_d       = '0;
                    trk_pend_d = trk_pend_q & ~trk_cur_oh;
                    if (|(pt_pend_q & trk_cur_oh)) state_d = ST_PTLF;
                    else if (|trk_pend_d)          state_d = ST_TRKF;
                    else                           state_d = ST_IDLE;
                end else begin
                    fr_d = fr_q + FRC_W'(1);
                end
            end
            ST_PTLF: begin
                rem_d     = rem_q - LEN_W'(1);
                pt_pend_d = '0;
                if (|trk_pend_q) state_d = ST_TRKF;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fr_q       <= '0;
            mb_pend_q  <= '0;
            trk_pend_q <= '0;
            pt_pend_q  <= '0;
            rem_q      <= '0;
        end else begin
            state_q    <= state_d;
            fr_q       <= fr_d;
            mb_pend_q  <= mb_pend_d;
            trk_pend_q <= trk_pend_d;
            pt_pend_q  <= pt_pend_d;
            rem_q      <= rem_d;
        end
    end

    // snapshot taken on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q       <= '0;
            modew_q      <= '0;
            mb_frames_q  <= '0;
            trk_frames_q <= '0;
            pt_frame_q   <= '0;
        end else if (accept) begin
            sync_q       <= err_vec;
            modew_q      <= DW'({mb_nz, trk_mode_i});
            mb_frames_q  <= mb_frames_i;
            trk_frames_q <= trk_frames_i;
            pt_frame_q   <= ptlut_frame_i;
        end
    end

    // outputs
    always_comb begin
        out_valid_o = (state_q != ST_IDLE);
        out_last_o  = out_valid_o && (rem_q == LEN_W'(1));
        out_data_o  = '0;
        unique case (state_q)
            ST_IDLE: out_data_o = '0;
            ST_SYNC: out_data_o = {1'b0, DW'(sync_q)};
            ST_MODE: out_data_o = {1'b0, modew_q};
            ST_MBF:  out_data_o = {1'b0, mb_frames_q[mb_pos*DW +: DW]};
            ST_TRKF: out_data_o = {1'b0, trk_frames_q[trk_pos*DW +: DW]};
            ST_PTLF: out_data_o = {1'b0, pt_frame_q};
            default: out_data_o = '0;
        endcase
    end

endmodule

// File: rtl/sp_data_packer_chk.sv
module sp_data_packer_chk #(
    parameter int unsigned N_FPGA      = 5,
    parameter int unsigned MU_PER_FPGA = 3,
    parameter int unsigned BX_W        = 3,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned MAX_LEN     = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          l1_reset_i,
    input logic                          start_i,
    input logic [BX_W-1:0]               num_bx_i,
    input logic [N_FPGA*MU_PER_FPGA-1:0] front_loss_i,
    input logic [N_FPGA-1:0]             sp_loss_i,
    input logic                          out_valid_o,
    input logic [WORD_W-1:0]             out_data_o,
    input logic                          out_last_o,
    input logic [N_FPGA*MU_PER_FPGA-1:0] sticky
);

    logic [7:0] wc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           wc <= '0;
        else if (out_valid_o) wc <= out_last_o ? 8'd0 : wc + 8'd1;
    end

    AST_START_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !out_valid_o && num_bx_i != '0) |=> (out_valid_o && !out_last_o)); // R1

    AST_ZERO_BX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !out_valid_o && num_bx_i == '0) |=> !out_valid_o); // R1

    AST_FRONT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!l1_reset_i && front_loss_i != '0) |=> ((sticky & $past(front_loss_i)) == $past(front_loss_i))); // R3

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !l1_reset_i |=> ((sticky & $past(sticky)) == $past(sticky))); // R3

    for (genvar f = 0; f < N_FPGA; f++) begin : g_sp
        AST_SP_LOSS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!l1_reset_i && sp_loss_i[f]) |=> (&sticky[f*MU_PER_FPGA +: MU_PER_FPGA])); // R4
    end

    AST_L1R_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        l1_reset_i |=> (sticky == '0)); // R5

    AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !out_data_o[WORD_W-1]); // R10

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |=> !out_valid_o); // R10

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_last_o) |-> (wc >= 8'd1 && wc <= 8'(MAX_LEN - 1))); // R10

endmodule

bind sp_data_packer sp_data_packer_chk #(
    .N_FPGA      (N_FPGA),
    .MU_PER_FPGA (MU_PER_FPGA),
    .BX_W        (BX_W),
    .WORD_W      (WORD_W),
    .MAX_LEN     (MAX_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .l1_reset_i   (l1_reset_i),
    .start_i      (start_i),
    .num_bx_i     (num_bx_i),
    .front_loss_i (front_loss_i),
    .sp_loss_i    (sp_loss_i),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_last_o   (out_last_o),
    .sticky       (sticky_w)
);

// File: tb/tb_sp_data_packer.sv
module tb_sp_data_packer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         l1r = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   nbx = '0;
    logic         zs = 1'b0;
    logic         mba = 1'b0;
    logic [1:0]   sel = '0;
    logic [14:0]  link = '0;
    logic [14:0]  fl = '0;
    logic [4:0]   sl = '0;
    logic [5:0]   mbq = '0;
    logic [59:0]  mbfr = '0;
    logic [11:0]  modes = '0;
    logic [134:0] trkfr = '0;
    logic [14:0]  ptw = '0;
    logic         out_valid;
    logic [15:0]  out_data;
    logic         out_last;

    always #5 clk = ~clk;

    sp_data_packer dut (
        .clk(clk), .rst_n(rst_n), .l1_reset_i(l1r), .start_i(start),
        .num_bx_i(nbx), .zero_sup_i(zs), .mb_active_i(mba), .ptlut_sel_i(sel),
        .link_err_i(link), .front_loss_i(fl), .sp_loss_i(sl),
        .mb_qual_i(mbq), .mb_frames_i(mbfr), .trk_mode_i(modes),
        .trk_frames_i(trkfr), .ptlut_frame_i(ptw),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last)
    );

    int checks = 0;
    int fails  = 0;
    logic [14:0] sticky_m = '0;
    logic [15:0] exp_w [0:15];
    int          exp_n;
    logic [15:0] got_w [0:15];
    int          got_n;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [14:0] spread(input logic [4:0] s);
        logic [14:0] r;
        for (int f = 0; f < 5; f++) r[f*3 +: 3] = {3{s[f]}};
        return r;
    endfunction

    task automatic push(input logic [15:0] w);
        exp_w[exp_n] = w;
        exp_n++;
    endtask

    // builds the expected block from the requirements; updates latched model
    task automatic build_exp();
        logic [14:0] e;
        e = link | fl | spread(sl) | (l1r ? 15'h0 : sticky_m);
        sticky_m = l1r ? 15'h0 : (sticky_m | fl | spread(sl));
        exp_n = 0;
        if (nbx == 0) return;
        push({1'b0, e});                                             // R2
        push({2'b00, mbq[5:3] != 0, mbq[2:0] != 0, modes});          // R6
        for (int i = 0; i < 2; i++)
            if (mba && (!zs || mbq[i*3 +: 3] != 0))                  // R7
                for (int f = 0; f < 2; f++) push({1'b0, mbfr[(i*2+f)*15 +: 15]});
        for (int k = 0; k < 3; k++)
            if (!zs || modes[k*4 +: 4] != 0) begin                   // R8
                for (int f = 0; f < 3; f++) push({1'b0, trkfr[(k*3+f)*15 +: 15]});
                if (sel == 2'(k + 1)) push({1'b0, ptw});             // R9
            end
    endtask

    task automatic pulse_err(input logic [14:0] f_i, input logic [4:0] s_i, input logic r_i);
        @(negedge clk);
        fl = f_i; sl = s_i; l1r = r_i;
        sticky_m = r_i ? 15'h0 : (sticky_m | f_i | spread(s_i));
        @(negedge clk);
        fl = '0; sl = '0; l1r = 1'b0;
    endtask

    task automatic run_block(input string tag, input bit busy_start);
        @(negedge clk);
        start = 1'b1;
        build_exp();
        @(negedge clk);
        start = 1'b0; link = '0; fl = '0; sl = '0; l1r = 1'b0;
        got_n = 0;
        for (int i = 0; i < exp_n; i++) begin
            chk(out_valid === 1'b1, {tag, " R10 valid"}, 32'(out_valid), 1);
            chk(out_data === exp_w[i], {tag, " R2/R6/R7/R8/R9 word"}, 32'(out_data), 32'(exp_w[i]));
            chk(out_last === (i == exp_n - 1), {tag, " R10 last"}, 32'(out_last), 32'(i == exp_n - 1));
            got_w[i] = out_data;
            got_n++;
            if (busy_start && i == 1) start = 1'b1;   // R1: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        chk(out_valid === 1'b0, {tag, " R1 idle after block"}, 32'(out_valid), 0);
        if (exp_n == 0) begin
            @(negedge clk);
            chk(out_valid === 1'b0, {tag, " R1 no block"}, 32'(out_valid), 0);
        end
    endtask

    task automatic rand_data();
        mbq = 6'($urandom);
        if ($urandom % 3 == 0) mbq[2:0] = '0;
        if ($urandom % 3 == 0) mbq[5:3] = '0;
        for (int k = 0; k < 3; k++) modes[k*4 +: 4] = ($urandom % 2) ? 4'($urandom) : 4'h0;
        for (int i = 0; i < 4; i++) mbfr[i*15 +: 15] = 15'($urandom);
        for (int i = 0; i < 9; i++) trkfr[i*15 +: 15] = 15'($urandom);
        ptw = 15'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 0);
        chk(out_last === 1'b0, "R10 reset last", 32'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: crossing count 0 gives nothing
        rand_data(); nbx = 3'd0; mba = 1'b1;
        run_block("R1 zero bx", 1'b0);

        // full block: 16 words, PT frame after track 3 (R9, R10)
        rand_data(); nbx = 3'd4; zs = 1'b0; mba = 1'b1; sel = 2'd3;
        run_block("full", 1'b1);
        chk(got_n == 16, "R10 max length", 32'(got_n), 16);

        // minimal block (R10)
        modes = '0; zs = 1'b1; mba = 1'b0; sel = 2'd1;
        run_block("min", 1'b0);
        chk(got_n == 2, "R10 min length", 32'(got_n), 2);

        // word 1 layout (R6)
        modes = 12'hA05; mbq = 6'b011_000; zs = 1'b1; mba = 1'b1; sel = 2'd2;
        run_block("mode word", 1'b0);
        chk(got_w[1] == 16'h2A05, "R6 mode word", 32'(got_w[1]), 32'h2A05);
        chk(got_n == 2 + 2 + 6, "R9 no PT on excluded track", 32'(got_n), 10);

        // latched errors
        zs = 1'b1; modes = '0; mba = 1'b0; sel = 2'd0;
        pulse_err(15'h0010, 5'h0, 1'b0);
        run_block("front", 1'b0);
        chk(got_w[0] == 16'h0010, "R3 front loss latched", 32'(got_w[0]), 32'h0010);
        pulse_err(15'h0, 5'b00100, 1'b0);
        run_block("sp", 1'b0);
        chk(got_w[0] == 16'h01D0, "R4 sp loss spread", 32'(got_w[0]), 32'h01D0);
        link = 15'h0001;
        run_block("link", 1'b0);
        chk(got_w[0] == 16'h01D1, "R2 link error present", 32'(got_w[0]), 32'h01D1);
        run_block("link gone", 1'b0);
        chk(got_w[0] == 16'h01D0, "R2 link error transient", 32'(got_w[0]), 32'h01D0);
        pulse_err(15'h0, 5'h0, 1'b1);
        run_block("l1r", 1'b0);
        chk(got_w[0] == 16'h0000, "R5 cleared", 32'(got_w[0]), 32'h0);
        pulse_err(15'h4000, 5'h0, 1'b0);
        l1r = 1'b1; fl = 15'h0002;
        run_block("l1r same cycle", 1'b0);
        chk(got_w[0] == 16'h0002, "R5 same-cycle sources only", 32'(got_w[0]), 32'h0002);
        run_block("after l1r", 1'b0);
        chk(got_w[0] == 16'h0000, "R5 nothing latched", 32'(got_w[0]), 32'h0);

        // constrained random mix
        for (int n = 0; n < 80; n++) begin
            rand_data();
            nbx   = ($urandom % 6 == 0) ? 3'd0 : 3'($urandom % 7 + 1);
            zs    = 1'($urandom);
            mba   = 1'($urandom);
            sel   = 2'($urandom);
            link  = ($urandom % 3 == 0) ? 15'($urandom) : 15'h0;
            fl    = ($urandom % 5 == 0) ? (15'h1 << ($urandom % 15)) : 15'h0;
            sl    = ($urandom % 6 == 0) ? (5'h1 << ($urandom % 5)) : 5'h0;
            l1r   = ($urandom % 8 == 0);
            run_block("rand R7/R8/R9", ($urandom % 4 == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule